// File: doc/BRIEF.md
# Per-Line Edge Detector Bank

The block monitors a wide bus of independent single-bit lines (256 by default) and, for every line, raises a one-cycle event when that line makes the transition its configuration asks for. Each line can be set to catch a rise, a fall, or any change. Each line can also be silenced by a per-line mask bit. Detection compares the present input value with a sample registered one clock earlier. The events leave the block as a registered per-line vector, together with a registered flag that is set whenever any line fired in the same cycle.

Software programs the block through a plain word port. The port has a byte address, a one-cycle write strobe, write data, and read data that follows the address combinationally. Line modes are packed two bits per line into a bank of 32-bit mode words. Mask bits are packed one bit per line into a second bank of 32-bit words. A two-state sequencer holds detection off for the first sampling edge after reset, because the previous-sample registers do not yet hold real input history on that edge. The sequencer has two states. ST_WARMUP is entered on reset. It moves to ST_ARMED unconditionally on the first clock edge and then stays in ST_ARMED until the next reset.

Top module: `edge_detect_bank`

## Requirements
- R1: After reset every mode word and every mask word reads zero, `evt_o` is all zero and `evt_any_o` is zero.
- R2: A line with mode code 2'b00 raises its `evt_o` bit in the cycle after the clock edge at which its input is 1 and its previous sample was 0. A fall on that line gives no event.
- R3: A line with mode code 2'b01 raises its event for a 1-to-0 transition only.
- R4: A line with mode code 2'b10 raises its event for a transition in either direction.
- R5: Mode code 2'b11 never produces an event, and a word containing it reads back exactly as written.
- R6: A mask bit of 1 forces the event of its own line to 0 and leaves every other line unaffected.
- R7: Line r takes its mode from bits [(r mod 16)*2+1 : (r mod 16)*2] of the mode word at byte address 0x808 + 4*(r/16). It takes its mask from bit (r mod 32) of the mask word at byte address 0x848 + 4*(r/32). With 256 lines there are 16 mode words and 8 mask words.
- R8: No event is reported for the first clock edge after reset, whatever the inputs are.
- R9: An event lasts exactly one cycle. A line that holds its level produces no further event.
- R10: `evt_any_o` is 1 in exactly the cycles in which at least one bit of `evt_o` is 1.
- R11: A write to any address outside the two word banks, or to an address that is not word-aligned, changes no register. A read from such an address returns zero.
- R12: A register write applied at a clock edge affects detection from the next edge onward. The edge that performs the write still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | NUM_LINES | Monitored lines |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr_en | input | 1 | Write strobe, one word per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_o | output | NUM_LINES | Registered per-line event pulses |
| evt_any_o | output | 1 | Registered OR of the events of the same cycle |

## Verification
The bound checker watches several rules on every cycle. It confirms that the combined flag agrees with the event vector. It confirms that no masked line and no line in the reserved mode ever reports an event one edge after that setting was in force. It confirms that the cycle after the warm-up edge is quiet, and that every address outside the map reads zero. The bench's scenarios are needed for the rest. Only they can show that each mode fires on the correct direction of transition, that the bit packing maps each field to the intended line, and that a pulse ends after one cycle. They also show that a write landing on the same edge as an input transition is judged by the old setting, and that misaligned or unmapped writes leave the stored words untouched.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MODE_W    = 2;
    localparam int unsigned CTRL_BASE = 'h808;
    localparam int unsigned MASK_BASE = 'h848;

    typedef enum logic [MODE_W-1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_mode_e;

    typedef enum logic {
        ST_WARMUP = 1'b0,
        ST_ARMED  = 1'b1
    } arm_state_e;

    // Decide whether a (current, previous) sample pair satisfies a mode.
    function automatic logic edge_match(input edge_mode_e mode,
                                        input logic cur,
                                        input logic prv);
        logic res;
        unique case (mode)
            EDGE_RISE: res = cur & ~prv;
            EDGE_FALL: res = ~cur & prv;
            EDGE_BOTH: res = cur ^ prv;
            EDGE_RSVD: res = 1'b0;
            default:   res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/edge_bank_regs.sv
module edge_bank_regs
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr_en,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [MODE_W*NUM_LINES-1:0] mode_flat,
    output logic [NUM_LINES-1:0]    mask_line
);

    localparam int unsigned LINES_PER_CTRL = WORD_W / MODE_W;
    localparam int unsigned LINES_PER_MASK = WORD_W;
    localparam int unsigned CTRL_WORDS     = NUM_LINES / LINES_PER_CTRL;
    localparam int unsigned MASK_WORDS     = NUM_LINES / LINES_PER_MASK;
    localparam int unsigned CIDX_W         = (CTRL_WORDS > 1) ? $clog2(CTRL_WORDS) : 1;
    localparam int unsigned MIDX_W         = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1;

    localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE);
    localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * CTRL_WORDS);
    localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_BASE + 4 * MASK_WORDS);

    logic [WORD_W-1:0] ctrl_q [CTRL_WORDS];
    logic [WORD_W-1:0] mask_q [MASK_WORDS];

    logic              aligned;
    logic              ctrl_hit;
    logic              mask_hit;
    logic [CIDX_W-1:0] ctrl_idx;
    logic [MIDX_W-1:0] mask_idx;

    // Address decode: word-aligned and inside one of the two banks.
    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        ctrl_hit = aligned && (bus_addr >= CTRL_LO) && (bus_addr < CTRL_HI);
        mask_hit = aligned && (bus_addr >= MASK_LO) && (bus_addr < MASK_HI);
        ctrl_idx = CIDX_W'((bus_addr - CTRL_LO) >> 2);
        mask_idx = MIDX_W'((bus_addr - MASK_LO) >> 2);
    end

    // Mode word storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < CTRL_WORDS; w++) begin
                ctrl_q[w] <= '0;
            end
        end else if (bus_wr_en && ctrl_hit) begin
            ctrl_q[ctrl_idx] <= bus_wdata;
        end
    end

    // Mask word storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < MASK_WORDS; w++) begin
                mask_q[w] <= '0;
            end
        end else if (bus_wr_en && mask_hit) begin
            mask_q[mask_idx] <= bus_wdata;
        end
    end

    // Read return, zero outside the map.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata = ctrl_q[ctrl_idx];
        end else if (mask_hit) begin
            bus_rdata = mask_q[mask_idx];
        end
    end

    // Unpack the words into per-line fields.
    for (genvar r = 0; r < NUM_LINES; r++) begin : g_unpack
        assign mode_flat[MODE_W*r +: MODE_W] =
            ctrl_q[r / LINES_PER_CTRL][(r % LINES_PER_CTRL) * MODE_W +: MODE_W];
        assign mask_line[r] = mask_q[r / LINES_PER_MASK][r % LINES_PER_MASK];
    end

endmodule

// File: rtl/edge_bank_seq.sv
module edge_bank_seq
    import edge_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed_o
);

    arm_state_e state_q;
    arm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARMUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state: warm-up lasts one edge, armed is terminal until reset.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARMUP: state_d = ST_ARMED;
            ST_ARMED:  state_d = ST_ARMED;
            default:   state_d = ST_WARMUP;
        endcase
    end

    // Outputs.
    always_comb begin
        armed_o = 1'b0;
        unique case (state_q)
            ST_WARMUP: armed_o = 1'b0;
            ST_ARMED:  armed_o = 1'b1;
            default:   armed_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/edge_bank_lane.sv
module edge_bank_lane
    import edge_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              mask_i,
    input  logic              armed_i,
    output logic              hit_o,
    output logic              evt_o
);

    logic prev_q;

    always_comb begin
        hit_o = armed_i && !mask_i && edge_match(edge_mode_e'(mode_i), line_i, prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            evt_o  <= 1'b0;
        end else begin
            prev_q <= line_i;
            evt_o  <= hit_o;
        end
    end

endmodule

// File: rtl/edge_detect_bank.sv
module edge_detect_bank
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] evt_o,
    output logic                 evt_any_o
);

    logic [MODE_W*NUM_LINES-1:0] mode_flat;
    logic [NUM_LINES-1:0]        mask_line;
    logic [NUM_LINES-1:0]        hit_vec;
    logic                        armed;

    edge_bank_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode_flat (mode_flat),
        .mask_line (mask_line)
    );

    edge_bank_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_o (armed)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        edge_bank_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (lines_i[g]),
            .mode_i  (mode_flat[MODE_W*g +: MODE_W]),
            .mask_i  (mask_line[g]),
            .armed_i (armed),
            .hit_o   (hit_vec[g]),
            .evt_o   (evt_o[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_any_o <= 1'b0;
        end else begin
            evt_any_o <= |hit_vec;
        end
    end

endmodule

// File: rtl/edge_detect_bank_chk.sv
module edge_detect_bank_chk #(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NUM_LINES-1:0]   evt_o,
    input logic                   evt_any_o,
    input logic [2*NUM_LINES-1:0] mode_flat,
    input logic [NUM_LINES-1:0]   mask_line
);

    localparam int unsigned C_LO = 'h808;
    localparam int unsigned C_HI = 'h808 + 4 * (NUM_LINES / 16);
    localparam int unsigned M_LO = 'h848;
    localparam int unsigned M_HI = 'h848 + 4 * (NUM_LINES / 32);

    logic [NUM_LINES-1:0] rsv_line;
    logic                 seen_q;
    logic                 in_map;

    for (genvar r = 0; r < NUM_LINES; r++) begin : g_rsv
        assign rsv_line[r] = &mode_flat[2*r +: 2];
    end

    always_comb begin
        in_map = (bus_addr[1:0] == 2'b00) &&
                 (((32'(bus_addr) >= C_LO) && (32'(bus_addr) < C_HI)) ||
                  ((32'(bus_addr) >= M_LO) && (32'(bus_addr) < M_HI)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assert_any_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any_o == (|evt_o));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_o & $past(mask_line)) == '0));

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_o & $past(rsv_line)) == '0));

    assert_warmup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> ((evt_o == '0) && !evt_any_o));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_map |-> (bus_rdata == '0));

endmodule

bind edge_detect_bank edge_detect_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .evt_o     (evt_o),
    .evt_any_o (evt_any_o),
    .mode_flat (mode_flat),
    .mask_line (mask_line)
);

// File: tb/edge_detect_bank_bench.sv
`timescale 1ns/1ps
module edge_detect_bank_bench;

    localparam int N = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   lines = '0;
    logic [11:0]    bus_addr = '0;
    logic           bus_wr_en = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   evt_o;
    logic           evt_any_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    edge_detect_bank u_edge_detect_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_i   (lines),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_o     (evt_o),
        .evt_any_o (evt_any_o)
    );

    // Behavioural reference model.
    logic [31:0]  ctrl_m [16];
    logic [31:0]  mask_m [8];
    logic [N-1:0] prev_m  = '0;
    logic [N-1:0] exp_evt = '0;
    logic         exp_any = 1'b0;
    bit           armed_m = 1'b0;

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int ai;
        ai = int'(a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (ai >= 'h808 && ai < 'h848) return ctrl_m[(ai - 'h808) / 4];
        if (ai >= 'h848 && ai < 'h868) return mask_m[(ai - 'h848) / 4];
        return 32'h0;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) ctrl_m[i] = '0;
        for (int i = 0; i < 8; i++)  mask_m[i] = '0;
    end

    always @(posedge clk) begin
        int           m;
        int           ai;
        bit           c, p, h;
        logic [N-1:0] nxt;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ctrl_m[i] = '0;
            for (int i = 0; i < 8; i++)  mask_m[i] = '0;
            prev_m  = '0;
            exp_evt = '0;
            exp_any = 1'b0;
            armed_m = 1'b0;
        end else begin
            nxt = '0;
            for (int r = 0; r < N; r++) begin
                m = int'((ctrl_m[r / 16] >> ((r % 16) * 2)) & 32'h3);
                c = lines[r];
                p = prev_m[r];
                case (m)
                    0: h = c && !p;
                    1: h = !c && p;
                    2: h = c != p;
                    default: h = 1'b0;
                endcase
                nxt[r] = armed_m && h && !mask_m[r / 32][r % 32];
            end
            exp_evt = nxt;
            exp_any = |nxt;
            prev_m  = lines;
            armed_m = 1'b1;
            if (bus_wr_en && bus_addr[1:0] == 2'b00) begin
                ai = int'(bus_addr);
                if (ai >= 'h808 && ai < 'h848) ctrl_m[(ai - 'h808) / 4] = bus_wdata;
                else if (ai >= 'h848 && ai < 'h868) mask_m[(ai - 'h848) / 4] = bus_wdata;
            end
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R2 R3 R4 R10 lanes).
    always @(negedge clk) begin
        if (!done) begin
            chk("R9 per-cycle evt_o", evt_o, exp_evt);
            chk("R10 per-cycle evt_any_o", N'(evt_any_o), N'(exp_any));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, N'(bus_rdata), N'(exp));
    endtask

    function automatic logic [N-1:0] bitv(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        logic [11:0] ra;
        int          sel;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 evt_o in reset", evt_o, '0);
        chk("R1 evt_any_o in reset", N'(evt_any_o), '0);
        for (int w = 0; w < 24; w++) rd("R1 word reads zero", 12'('h808 + 4 * w), 32'h0);

        // R8: inputs high at release, no event on the first edge
        lines = '1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 first edge quiet", evt_o, '0);
        @(negedge clk);
        chk("R9 held level quiet", evt_o, '0);

        // R2: falls ignored in rise mode, then a rise on line 5
        lines = '0;
        @(negedge clk);
        chk("R2 fall ignored", evt_o, '0);
        lines[5] = 1'b1;
        @(negedge clk);
        chk("R2 rise line5", evt_o, bitv(5));
        chk("R10 any with event", N'(evt_any_o), N'(1));
        @(negedge clk);
        chk("R9 pulse ends", evt_o, '0);
        chk("R10 any cleared", N'(evt_any_o), '0);

        // R3: line 1 to falling mode
        wr(12'h808, 32'h4);
        lines[1] = 1'b1;
        @(negedge clk);
        chk("R3 rise ignored", evt_o, '0);
        lines[1] = 1'b0;
        @(negedge clk);
        chk("R3 fall line1", evt_o, bitv(1));

        // R4 + R7: line 50 lives in word 3 bits [5:4]
        wr(12'h814, 32'h20);
        rd("R7 mode word 3 readback", 12'h814, 32'h20);
        lines[50] = 1'b1;
        @(negedge clk);
        chk("R4 toggle rise line50", evt_o, bitv(50));
        lines[50] = 1'b0;
        @(negedge clk);
        chk("R4 toggle fall line50", evt_o, bitv(50));

        // R5: reserved code on line 0
        wr(12'h808, 32'h7);
        rd("R5 reserved readback", 12'h808, 32'h7);
        lines[0] = 1'b1;
        @(negedge clk);
        chk("R5 reserved rise quiet", evt_o, '0);
        lines[0] = 1'b0;
        @(negedge clk);
        chk("R5 reserved fall quiet", evt_o, '0);

        // R6 + R7: mask line 77 (word 2 bit 13), neighbour 78 unmasked
        wr(12'h850, 32'h1 << 13);
        rd("R7 mask word 2 readback", 12'h850, 32'h1 << 13);
        lines[77] = 1'b1;
        lines[78] = 1'b1;
        @(negedge clk);
        chk("R6 mask only own line", evt_o, bitv(78));
        lines[77] = 1'b0;
        lines[78] = 1'b0;
        @(negedge clk);

        // R11: unmapped and misaligned writes
        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'h868, 32'hFFFF_FFFF);
        wr(12'h80A, 32'hFFFF_FFFF);
        wr(12'h84A, 32'hFFFF_FFFF);
        rd("R11 read 0x800", 12'h800, 32'h0);
        rd("R11 read 0x868", 12'h868, 32'h0);
        rd("R11 read 0x80A", 12'h80A, 32'h0);
        rd("R11 word0 untouched", 12'h808, 32'h7);
        rd("R11 mask2 untouched", 12'h850, 32'h1 << 13);

        // R12: write on the same edge as a rise on line 2 (rise -> fall mode)
        bus_addr  = 12'h808;
        bus_wdata = 32'h7 | (32'h1 << 4);
        bus_wr_en = 1'b1;
        lines[2]  = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk("R12 old mode on write edge", evt_o, bitv(2));
        lines[2] = 1'b0;
        @(negedge clk);
        chk("R12 new mode next edge", evt_o, bitv(2));

        // Mixed traffic checked by the model every clock
        lf = 32'h1234_5679;
        for (int k = 0; k < 3000; k++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            lines = lines ^ {8{lf & (lf >> 7) & (lf >> 3)}};
            if (k % 23 == 0) begin
                sel = int'(lf[20:16]) % 26;
                if (sel < 16)      ra = 12'('h808 + 4 * sel);
                else if (sel < 24) ra = 12'('h848 + 4 * (sel - 16));
                else               ra = 12'h870 + 12'(lf[1:0]);
                bus_addr  = ra;
                bus_wdata = lf ^ 32'h5A5A_A5A5;
                bus_wr_en = 1'b1;
            end else begin
                bus_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr_en = 1'b0;
        for (int w = 0; w < 24; w++) rd("R7 final readback", 12'('h808 + 4 * w),
                                         model_read(12'('h808 + 4 * w)));
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule